// File: doc/BRIEF.md
# Clause-45 MDIO Management Controller

This block is a bus-mapped MDIO master for extended (Clause-45) station management. Software loads a 16-bit target register address into a dedicated holding register. It then writes one command word to the management register. That single command runs a complete indirect access on the management bus. The first frame is an address frame that delivers the held register address to the selected port and device. The second frame writes the command's data or reads a value back.

While the two frames run, the management register reports busy. When a read finishes, the management register shows a read-valid flag and the captured 16-bit value. A configuration register selects the MDC rate with a 2-bit code that picks one of four fixed division ratios of the system clock. The code takes effect only when a command starts, so the MDC rate never changes inside a frame.

During the turnaround and data part of a read frame the controller releases MDIO. It samples the line on each rising MDC edge.

Top module: `mdio45_ctrl`

## Requirements
- R1: After reset the busy flag (management bit 30) and the read-valid flag (bit 29) are 0, the divider code reads 0, MDC is low and MDIO is not driven.
- R2: A write to offset 0x0 while idle starts a command only if bits [28:26] hold 3'b101 (write) or 3'b111 (read). Any other opcode is ignored: busy stays 0 and MDC stays still.
- R3: Each command first sends an address frame, MSB first, valid at each MDC rising edge. Its fields are 32 ones, start 00, opcode 00, port address (command bits [20:16]), device address (bits [25:21]), turnaround 10, and the 16-bit value held at offset 0x8.
- R4: For a write command the second frame carries 32 ones, 00, opcode 01, the same port and device addresses, turnaround 10, and command bits [15:0].
- R5: For a read command the second frame drives 32 ones, 00, opcode 11 and both addresses. MDIO is released for its last 18 bits, and the 16 data bits are sampled on MDC rising edges. At completion, bit 29 is set and bits [15:0] hold the sampled value, MSB first.
- R6: Busy is set from the accepted command write until after the 128th MDC rising edge of the command. MDC is low and MDIO is undriven while idle.
- R7: Read-valid is cleared when a new command is accepted and stays 0 after a write command.
- R8: Divider code 0, 1, 2 and 3 (offset 0xC bits [1:0]) gives an MDC period of 256, 64, 32 and 8 system clocks. Reading offset 0xC returns the code in bits [1:0] and zeros above.
- R9: A divider code written while busy is readable at once. It does not alter the MDC period of the command in progress and applies to the next command.
- R10: While busy, writes to offsets 0x0 and 0x8 are ignored. The held address and the command fields are unchanged, and no extra frames are sent.
- R11: Offset 0x8 reads back the last 16-bit address written while idle, with zeros in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable, 0 releases the line |

## Verification
The hardest state to reach is a change made while a command is still running. Examples are a divider code written in the middle of a frame, or a second command and a new address written while busy. From the ports these can only be seen through the MDC period and the bits of later frames. The bench acts as the PHY and counts MDC rising edges per command. Its directed tests issue these writes while busy, then compare the measured period, the full 128-bit sequence of captured bits and the edge count with values computed from the first command alone.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
    localparam int OFF_MGMT = 'h0;
    localparam int OFF_ADDR = 'h8;
    localparam int OFF_CFG  = 'hC;

    localparam logic [2:0] OPC_WR = 3'b101;
    localparam logic [2:0] OPC_RD = 3'b111;

    localparam int BUSY_BIT  = 30;
    localparam int VALID_BIT = 29;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ADDR = 2'd1,
        SEQ_DATA = 2'd2
    } seq_e;
endpackage

// File: rtl/mdio45_mdc_gen.sv
module mdio45_mdc_gen #(
    parameter int DIV0 = 256,
    parameter int DIV1 = 64,
    parameter int DIV2 = 32,
    parameter int DIV3 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] code,
    output logic       mdc,
    output logic       rise,
    output logic       fall
);
    localparam int MAX01 = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int MAX23 = (DIV2 > DIV3) ? DIV2 : DIV3;
    localparam int MAXD  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(MAXD / 2) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t q, d;
    logic [CNT_W-1:0] last;
    logic             wrap;

    always_comb begin
        case (code)
            2'd0:    last = CNT_W'(DIV0 / 2 - 1);
            2'd1:    last = CNT_W'(DIV1 / 2 - 1);
            2'd2:    last = CNT_W'(DIV2 / 2 - 1);
            default: last = CNT_W'(DIV3 / 2 - 1);
        endcase
        wrap = (q.cnt == last);
        d = q;
        if (!en) begin
            d = '0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc  = q.mdc;
    assign rise = en & wrap & ~q.mdc;
    assign fall = en & wrap & q.mdc;
endmodule

// File: rtl/mdio45_frame_eng.sv
module mdio45_frame_eng #(
    parameter int PRE_BITS = 32,
    localparam int FRAME_BITS = PRE_BITS + 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  rd_mode,
    input  logic [FRAME_BITS-1:0] vec,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [15:0]           rd_data
);
    localparam int IDX_W    = $clog2(FRAME_BITS);
    localparam int TA_POS   = PRE_BITS + 14;
    localparam int DATA_POS = PRE_BITS + 16;

    typedef struct packed {
        logic                  active;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [15:0]           rd_sh;
        logic                  done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.active = 1'b1;
            d.idx    = '0;
            d.sh     = vec;
            d.rd_sh  = '0;
        end else if (q.active) begin
            if (rise && rd_mode && (q.idx >= IDX_W'(DATA_POS))) begin
                d.rd_sh = {q.rd_sh[14:0], mdio_i};
            end
            if (fall) begin
                if (q.idx == IDX_W'(FRAME_BITS - 1)) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.sh  = {q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdio_o  = q.active ? q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = q.active & ~(rd_mode & (q.idx >= IDX_W'(TA_POS)));
    assign done    = q.done;
    assign rd_data = q.rd_sh;
endmodule

// File: rtl/mdio45_ctrl.sv
module mdio45_ctrl
    import mdio45_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int PRE_BITS = 32,
    parameter int DIV0     = 256,
    parameter int DIV1     = 64,
    parameter int DIV2     = 32,
    parameter int DIV3     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int FRAME_BITS = PRE_BITS + 32;

    typedef struct packed {
        seq_e        state;
        logic        start;
        logic [2:0]  op;
        logic [4:0]  dev;
        logic [4:0]  prt;
        logic [15:0] data;
        logic        rvalid;
        logic [15:0] reg_addr;
        logic [1:0]  cfg_code;
        logic [1:0]  act_code;
    } ctl_t;

    ctl_t q, d;

    logic                  wr_mgmt, wr_addr, wr_cfg, op_ok;
    logic                  eng_done, tick_rise, tick_fall, is_read;
    logic [15:0]           eng_rd;
    logic [FRAME_BITS-1:0] frame_vec;

    logic        busy;
    logic        rd_valid;
    logic [1:0]  act_code;
    logic [15:0] reg_addr_q;

    assign wr_mgmt = bus_wr && (bus_addr == ADDR_W'(OFF_MGMT));
    assign wr_addr = bus_wr && (bus_addr == ADDR_W'(OFF_ADDR));
    assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(OFF_CFG));
    assign op_ok   = (bus_wdata[28:26] == OPC_WR) || (bus_wdata[28:26] == OPC_RD);
    assign is_read = (q.op == OPC_RD);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        case (q.state)
            SEQ_IDLE: begin
                d.act_code = q.cfg_code;
                if (wr_addr) d.reg_addr = bus_wdata[15:0];
                if (wr_mgmt && op_ok) begin
                    d.state  = SEQ_ADDR;
                    d.start  = 1'b1;
                    d.op     = bus_wdata[28:26];
                    d.dev    = bus_wdata[25:21];
                    d.prt    = bus_wdata[20:16];
                    d.data   = bus_wdata[15:0];
                    d.rvalid = 1'b0;
                end
            end
            SEQ_ADDR: begin
                if (eng_done) begin
                    d.state = SEQ_DATA;
                    d.start = 1'b1;
                end
            end
            SEQ_DATA: begin
                if (eng_done) begin
                    d.state = SEQ_IDLE;
                    if (is_read) begin
                        d.data   = eng_rd;
                        d.rvalid = 1'b1;
                    end
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
        if (wr_cfg) d.cfg_code = bus_wdata[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (q.state == SEQ_DATA) begin
            frame_vec = {{PRE_BITS{1'b1}}, 2'b00, (is_read ? 2'b11 : 2'b01),
                         q.prt, q.dev, 2'b10, (is_read ? 16'h0000 : q.data)};
        end else begin
            frame_vec = {{PRE_BITS{1'b1}}, 2'b00, 2'b00,
                         q.prt, q.dev, 2'b10, q.reg_addr};
        end
    end

    assign busy       = (q.state != SEQ_IDLE);
    assign rd_valid   = q.rvalid;
    assign act_code   = q.act_code;
    assign reg_addr_q = q.reg_addr;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_MGMT)) begin
            bus_rdata[15:0]      = q.data;
            bus_rdata[20:16]     = q.prt;
            bus_rdata[25:21]     = q.dev;
            bus_rdata[28:26]     = q.op;
            bus_rdata[VALID_BIT] = q.rvalid;
            bus_rdata[BUSY_BIT]  = busy;
        end else if (bus_addr == ADDR_W'(OFF_ADDR)) begin
            bus_rdata[15:0] = q.reg_addr;
        end else if (bus_addr == ADDR_W'(OFF_CFG)) begin
            bus_rdata[1:0] = q.cfg_code;
        end
    end

    mdio45_mdc_gen #(
        .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
    ) i_mdc_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .code (q.act_code),
        .mdc  (mdc),
        .rise (tick_rise),
        .fall (tick_fall)
    );

    mdio45_frame_eng #(
        .PRE_BITS(PRE_BITS)
    ) i_frame_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (q.start),
        .rd_mode(is_read && (q.state == SEQ_DATA)),
        .vec    (frame_vec),
        .rise   (tick_rise),
        .fall   (tick_fall),
        .mdio_i (mdio_i),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .done   (eng_done),
        .rd_data(eng_rd)
    );
endmodule

// File: rtl/mdio45_ctrl_chk.sv
module mdio45_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        rd_valid,
    input logic [1:0]  act_code,
    input logic [15:0] reg_addr,
    input logic        mdc,
    input logic        mdio_oe
);
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_drive_in_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    p_rate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(act_code));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(reg_addr));

    p_valid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rd_valid);

    p_valid_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (!busy && $past(busy)));
endmodule

bind mdio45_ctrl mdio45_ctrl_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .rd_valid(rd_valid),
    .act_code(act_code),
    .reg_addr(reg_addr_q),
    .mdc     (mdc),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio45_ctrl.sv
`timescale 1ns/1ps
module test_mdio45_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_i, mdio_o, mdio_oe;

    int total = 0;
    int fails = 0;
    int rises = 0;
    int base = 0;
    int phy_k;
    logic [15:0] resp = 16'h0;
    logic cap_v  [0:127];
    logic cap_oe [0:127];
    realtime t_r0, t_r1;

    always #10 clk = ~clk;

    mdio45_ctrl i_mdio45_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY model: counts rising MDC edges per command, captures, answers reads
    assign phy_k  = rises - base;
    assign mdio_i = (phy_k >= 112 && phy_k < 128) ? resp[127 - phy_k] : 1'b1;

    always @(posedge mdc) begin
        if (phy_k >= 0 && phy_k < 128) begin
            cap_v[phy_k]  = mdio_o;
            cap_oe[phy_k] = mdio_oe;
        end
        if (phy_k == 0) t_r0 = $realtime;
        if (phy_k == 1) t_r1 = $realtime;
        rises = rises + 1;
    end

    // code, read, port, device, register address, data/response, period
    localparam logic [53:0] VECS [5] = '{
        {2'd3, 1'b0, 5'd1,  5'd1,  16'h0000, 16'hBEEF, 9'd8},
        {2'd3, 1'b1, 5'd31, 5'd30, 16'hFFFF, 16'h1234, 9'd8},
        {2'd2, 1'b0, 5'd0,  5'd31, 16'h8001, 16'h0000, 9'd32},
        {2'd1, 1'b1, 5'd17, 5'd3,  16'h7FFE, 16'hFFFF, 9'd64},
        {2'd3, 1'b1, 5'd10, 5'd21, 16'hAAAA, 16'h0001, 9'd8}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int n = 0; n < 60000; n++) begin
            bus_read(4'h0, v);
            if (!v[30]) break;
        end
    endtask

    function automatic logic [31:0] mgmt_word(input logic rd, input logic [4:0] prt,
                                              input logic [4:0] dev, input logic [15:0] dt);
        return {3'b000, (rd ? 3'b111 : 3'b101), dev, prt, dt};
    endfunction

    task automatic start_cmd(input logic rd, input logic [4:0] prt, input logic [4:0] dev,
                             input logic [15:0] ra, input logic [15:0] dt);
        resp = dt;
        base = rises;
        bus_write(4'h8, {16'h0, ra});
        bus_write(4'h0, mgmt_word(rd, prt, dev, dt));
    endtask

    task automatic check_frame(input logic rd, input logic [4:0] prt, input logic [4:0] dev,
                               input logic [15:0] ra, input logic [15:0] dt, input string tag);
        logic [127:0] expv;
        int bad;
        expv = {32'hFFFF_FFFF, 2'b00, 2'b00, prt, dev, 2'b10, ra,
                32'hFFFF_FFFF, 2'b00, (rd ? 2'b11 : 2'b01), prt, dev, 2'b10, dt};
        bad = -1;
        for (int k = 0; k < 128; k++) begin
            logic eoe;
            eoe = !(rd && k >= 110);
            if (cap_oe[k] !== eoe || (eoe && cap_v[k] !== expv[127 - k])) begin
                if (bad < 0) bad = k;
            end
        end
        chk(bad < 0, tag, bad, 32'hFFFF_FFFF);
    endtask

    task automatic check_period(input int clocks, input string tag);
        int got;
        got = int'((t_r1 - t_r0) / 20.0);
        chk(got == clocks, tag, got, clocks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(4'h0, v);
        chk(v[30] == 1'b0 && v[29] == 1'b0, "R1 busy/valid after reset", v, 0);
        bus_read(4'hC, v);
        chk(v == 32'h0, "R1 divider code after reset", v, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe after reset", {mdc, mdio_oe}, 0);

        // R8: config readback of code only
        bus_write(4'hC, 32'hFFFF_FFFE);
        bus_read(4'hC, v);
        chk(v == 32'h2, "R8 config readback", v, 32'h2);

        // Table of vectors: R3 R4 R5 R8 R11
        for (int i = 0; i < 5; i++) begin
            logic [1:0]  code;
            logic        rd;
            logic [4:0]  prt, dev;
            logic [15:0] ra, dt;
            int          per;
            {code, rd, prt, dev, ra, dt} = VECS[i][53:9];
            per = int'(VECS[i][8:0]);
            bus_write(4'hC, {30'h0, code});
            start_cmd(rd, prt, dev, ra, dt);
            bus_read(4'h8, v);
            chk(v == {16'h0, ra}, "R11 address register readback", v, {16'h0, ra});
            wait_idle();
            check_frame(rd, prt, dev, ra, dt, rd ? "R5 read frames" : "R4 write frames");
            check_frame(rd, prt, dev, ra, dt, "R3 address frame bits");
            check_period(per, "R8 mdc period");
            bus_read(4'h0, v);
            chk(v == ({1'b0, 1'b0, rd, 29'h0} | mgmt_word(rd, prt, dev, dt)),
                rd ? "R5 read result and valid" : "R7 write leaves valid clear",
                v, {1'b0, 1'b0, rd, 29'h0} | mgmt_word(rd, prt, dev, dt));
        end

        // R8: divide by 256 with code 0
        bus_write(4'hC, 32'h0);
        start_cmd(1'b0, 5'd2, 5'd4, 16'h0F0F, 16'hC3C3);
        wait_idle();
        check_period(256, "R8 mdc period code 0");

        // R2: illegal opcode ignored
        r0 = rises;
        bus_write(4'h0, {3'b000, 3'b001, 5'd1, 5'd1, 16'h5555});
        bus_read(4'h0, v);
        chk(v[30] == 1'b0, "R2 illegal opcode leaves busy clear", v, 0);
        repeat (300) @(negedge clk);
        chk(rises == r0, "R2 illegal opcode leaves mdc still", rises, r0);

        // R6 and R9: busy over the whole command, code change while busy
        bus_write(4'hC, 32'h3);
        start_cmd(1'b0, 5'd5, 5'd6, 16'h1357, 16'h2468);
        bus_read(4'h0, v);
        chk(v[30] == 1'b1, "R6 busy right after command", v, 32'h4000_0000);
        bus_write(4'hC, 32'h1);
        bus_read(4'hC, v);
        chk(v == 32'h1, "R9 new code readable while busy", v, 1);
        while (phy_k < 128) @(negedge clk);
        bus_read(4'h0, v);
        chk(v[30] == 1'b1, "R6 busy still set after last rising edge", v, 32'h4000_0000);
        wait_idle();
        check_period(8, "R9 running command keeps its rate");
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R6 idle mdc/oe", {mdc, mdio_oe}, 0);
        start_cmd(1'b0, 5'd5, 5'd6, 16'h1357, 16'h2468);
        wait_idle();
        check_period(64, "R9 next command uses new rate");

        // R10: writes while busy ignored
        bus_write(4'hC, 32'h3);
        start_cmd(1'b0, 5'd9, 5'd12, 16'hA5A5, 16'h0FF0);
        bus_write(4'h8, 32'h0000_1234);
        bus_write(4'h0, mgmt_word(1'b1, 5'd3, 5'd3, 16'h9999));
        bus_read(4'h8, v);
        chk(v == 32'h0000_A5A5, "R10 address write ignored while busy", v, 32'hA5A5);
        wait_idle();
        repeat (300) @(negedge clk);
        chk(phy_k == 128, "R10 no extra frames", phy_k, 128);
        check_frame(1'b0, 5'd9, 5'd12, 16'hA5A5, 16'h0FF0, "R10 frames unchanged");
        bus_read(4'h0, v);
        chk(v == mgmt_word(1'b0, 5'd9, 5'd12, 16'h0FF0), "R10 command fields unchanged",
            v, mgmt_word(1'b0, 5'd9, 5'd12, 16'h0FF0));

        // R7: read-valid cleared by a new command
        start_cmd(1'b1, 5'd7, 5'd8, 16'h0102, 16'h6A6A);
        wait_idle();
        bus_read(4'h0, v);
        chk(v[29] == 1'b1 && v[15:0] == 16'h6A6A, "R5 read valid before new command", v,
            32'h2000_6A6A);
        start_cmd(1'b0, 5'd7, 5'd8, 16'h0102, 16'h1111);
        bus_read(4'h0, v);
        chk(v[29] == 1'b0 && v[30] == 1'b1, "R7 valid cleared at command start", v,
            32'h4000_0000);
        wait_idle();
        bus_read(4'h0, v);
        chk(v[29] == 1'b0, "R7 valid clear after write command", v, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule